// File: doc/BRIEF.md
# Wired-AND Barrier Synchronisation Unit

This block provides a small set of barrier channels that several independent controllers share. Each channel acts like an open-collector line with a pull-up. The line reads high only when nothing is pulling it low. A controller joins a barrier by initialising on a channel, and from then on it pulls that channel low. When the controller has finished its own work it lets go of the line and waits. The last participant to let go lets the line float high, and every waiting controller on that channel is then released in the same cycle.

A supervising master can force any channel low with its own hold input. This covers the case where one participant finishes before the others have joined the channel. Channels are fully independent, so separate groups of controllers can synchronise without affecting one another. Deciding which controllers use which channel is left to the surrounding system.

Top module: `bsync_barrier`

## Requirements
- R1: After reset every controller is idle, no release output is asserted and every channel line reads high.
- R2: An init pulse on an idle controller stores the channel given on its select field, which is controller i's field sel_i[2*i+1:2*i]. From the next cycle the controller pulls that channel low.
- R3: A channel line is high exactly when no controller is pulling it and its master hold is low.
- R4: A done pulse on a pulling controller stops the pull from the next cycle and puts the controller into the waiting state.
- R5: A waiting controller whose channel line is high at a clock edge asserts its release output for exactly one cycle after that edge. It then returns to idle and no longer takes part in the channel.
- R6: All controllers waiting on a channel are released in the same cycle when the last pull is removed.
- R7: Channels are independent. Releasing one channel does not release, or change the line of, any other channel.
- R8: While the master hold of a channel is high, its line is low and no controller waiting on it is released. Release follows one cycle after the edge at which the hold is seen low.
- R9: A controller that is not waiting never receives a release, even when its channel line is high.
- R10: Done is ignored on an idle controller. Init is ignored on a pulling or waiting controller, and the stored channel does not change. When init and done arrive together on an idle controller, init takes effect and done is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_i | input | N_CTRL | Per-controller request to join the selected channel |
| done_i | input | N_CTRL | Per-controller signal that its work has finished |
| sel_i | input | N_CTRL*CHW | Channel number per controller, controller i at bits [i*CHW +: CHW] |
| hold_i | input | N_CHAN | Master hold per channel, forces that line low |
| release_o | output | N_CTRL | One-cycle release pulse per controller |
| line_o | output | N_CHAN | Current level of each channel line |

## Verification
A controller stuck in the wrong state shows up directly on the line outputs. A controller that is still pulling, or that joined the wrong channel, holds the wrong line low in the very cycle after the init or done edge. A wrong transition out of waiting shows up on the release outputs one edge after its line rises, as a missing pulse, a pulse that lasts too long, or a pulse to an idle controller. Every scenario therefore checks the lines right after each stimulus edge and checks the release outputs at the edge that follows.

// File: rtl/bsync_pkg.sv
package bsync_pkg;

    typedef enum logic [1:0] {
        MB_IDLE = 2'd0,
        MB_PULL = 2'd1,
        MB_WAIT = 2'd2
    } mb_state_e;

endpackage

// File: rtl/bsync_member.sv
module bsync_member #(
    parameter int CHW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           init_i,
    input  logic           done_i,
    input  logic [CHW-1:0] sel_i,
    input  logic           line_i,
    output logic           pull_o,
    output logic           wait_o,
    output logic [CHW-1:0] chan_o,
    output logic           release_o
);
    import bsync_pkg::*;

    typedef struct packed {
        mb_state_e      state;
        logic [CHW-1:0] chan;
        logic           rel;
    } member_t;

    member_t mb_d, mb_q;

    always_comb begin
        mb_d     = mb_q;
        mb_d.rel = 1'b0;
        case (mb_q.state)
            MB_IDLE: begin
                // a simultaneous done is dropped here
                if (init_i) begin
                    mb_d.state = MB_PULL;
                    mb_d.chan  = sel_i;
                end
            end
            MB_PULL: begin
                if (done_i) begin
                    mb_d.state = MB_WAIT;
                end
            end
            MB_WAIT: begin
                if (line_i) begin
                    mb_d.state = MB_IDLE;
                    mb_d.rel   = 1'b1;
                end
            end
            default: mb_d.state = MB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mb_q <= '{state: MB_IDLE, chan: '0, rel: 1'b0};
        end else begin
            mb_q <= mb_d;
        end
    end

    assign pull_o    = (mb_q.state == MB_PULL);
    assign wait_o    = (mb_q.state == MB_WAIT);
    assign chan_o    = mb_q.chan;
    assign release_o = mb_q.rel;

endmodule

// File: rtl/bsync_wire.sv
module bsync_wire #(
    parameter int N_CTRL = 8,
    parameter int N_CHAN = 4,
    parameter int CHW    = 2
) (
    input  logic [N_CTRL-1:0]     pull_i,
    input  logic [N_CTRL*CHW-1:0] chan_i,
    input  logic [N_CHAN-1:0]     hold_i,
    output logic [N_CHAN-1:0]     line_o
);
    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        logic low_d;
        always_comb begin
            low_d = hold_i[c];
            for (int i = 0; i < N_CTRL; i++) begin
                if (pull_i[i] && (chan_i[i*CHW +: CHW] == CHW'(c))) begin
                    low_d = 1'b1;
                end
            end
        end
        assign line_o[c] = ~low_d;
    end

endmodule

// File: rtl/bsync_barrier.sv
module bsync_barrier #(
    parameter int N_CTRL = 8,
    parameter int N_CHAN = 4,
    localparam int CHW   = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_CTRL-1:0]     init_i,
    input  logic [N_CTRL-1:0]     done_i,
    input  logic [N_CTRL*CHW-1:0] sel_i,
    input  logic [N_CHAN-1:0]     hold_i,
    output logic [N_CTRL-1:0]     release_o,
    output logic [N_CHAN-1:0]     line_o
);
    logic [N_CTRL-1:0]     pull_w;
    logic [N_CTRL-1:0]     wait_w;
    logic [N_CTRL-1:0]     tap_w;
    logic [N_CTRL*CHW-1:0] chan_w;
    logic [N_CHAN-1:0]     line_w;

    bsync_wire #(
        .N_CTRL(N_CTRL),
        .N_CHAN(N_CHAN),
        .CHW   (CHW)
    ) u_wire (
        .pull_i(pull_w),
        .chan_i(chan_w),
        .hold_i(hold_i),
        .line_o(line_w)
    );

    for (genvar i = 0; i < N_CTRL; i++) begin : g_mem
        assign tap_w[i] = line_w[chan_w[i*CHW +: CHW]];

        bsync_member #(
            .CHW(CHW)
        ) u_mem (
            .clk      (clk),
            .rst_n    (rst_n),
            .init_i   (init_i[i]),
            .done_i   (done_i[i]),
            .sel_i    (sel_i[i*CHW +: CHW]),
            .line_i   (tap_w[i]),
            .pull_o   (pull_w[i]),
            .wait_o   (wait_w[i]),
            .chan_o   (chan_w[i*CHW +: CHW]),
            .release_o(release_o[i])
        );
    end

    assign line_o = line_w;

endmodule

// File: rtl/bsync_barrier_chk.sv
module bsync_barrier_chk #(
    parameter int N_CTRL = 8,
    parameter int N_CHAN = 4,
    parameter int CHW    = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_CTRL-1:0]     init_i,
    input logic [N_CHAN-1:0]     hold_i,
    input logic [N_CTRL-1:0]     release_o,
    input logic [N_CHAN-1:0]     line_o,
    input logic [N_CTRL-1:0]     pull_w,
    input logic [N_CTRL-1:0]     wait_w,
    input logic [N_CTRL*CHW-1:0] chan_w
);
    for (genvar i = 0; i < N_CTRL; i++) begin : g_ctl
        a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
            release_o[i] |=> !release_o[i]);

        a_r9_release_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
            release_o[i] |-> $past(wait_w[i]));

        a_r2_init_pulls: assert property (@(posedge clk) disable iff (!rst_n)
            (init_i[i] && !pull_w[i] && !wait_w[i]) |=> pull_w[i]);

        a_r3_pull_low: assert property (@(posedge clk) disable iff (!rst_n)
            pull_w[i] |-> !line_o[chan_w[i*CHW +: CHW]]);
    end

    for (genvar c = 0; c < N_CHAN; c++) begin : g_ch
        a_r8_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
            hold_i[c] |-> !line_o[c]);
    end

endmodule

bind bsync_barrier bsync_barrier_chk #(
    .N_CTRL(N_CTRL),
    .N_CHAN(N_CHAN),
    .CHW   (CHW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_i   (init_i),
    .hold_i   (hold_i),
    .release_o(release_o),
    .line_o   (line_o),
    .pull_w   (pull_w),
    .wait_w   (wait_w),
    .chan_w   (chan_w)
);

// File: tb/sim_bsync_barrier.sv
module sim_bsync_barrier;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 8;
    localparam int NH = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] init_i = '0;
    logic [NC-1:0] done_i = '0;
    logic [NC*CW-1:0] sel_i = '0;
    logic [NH-1:0] hold_i = '0;
    logic [NC-1:0] release_o;
    logic [NH-1:0] line_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsync_barrier #(.N_CTRL(NC), .N_CHAN(NH)) u0 (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .done_i(done_i),
        .sel_i(sel_i), .hold_i(hold_i), .release_o(release_o), .line_o(line_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic join_ch(input logic [NC-1:0] m, input logic [CW-1:0] ch);
        for (int i = 0; i < NC; i++) if (m[i]) sel_i[i*CW +: CW] = ch;
        init_i = m;
        step();
        init_i = '0;
    endtask

    task automatic finish_ctl(input logic [NC-1:0] m);
        done_i = m;
        step();
        done_i = '0;
    endtask

    task automatic t_reset();
        check("R1 release after reset", 32'(release_o), 32'h0);
        check("R1 lines after reset", 32'(line_o), 32'hF);
    endtask

    task automatic t_basic();
        join_ch(8'h07, 2'd1);
        check("R2 line low after init", 32'(line_o), 32'hD);
        finish_ctl(8'h03);
        check("R4 line held by last puller", 32'(line_o), 32'hD);
        check("R5 no early release", 32'(release_o), 32'h0);
        finish_ctl(8'h04);
        check("R3 line high after last done", 32'(line_o), 32'hF);
        check("R5 release registered", 32'(release_o), 32'h0);
        step();
        check("R6 group released together", 32'(release_o), 32'h07);
        step();
        check("R5 single-cycle pulse", 32'(release_o), 32'h0);
    endtask

    task automatic t_indep();
        join_ch(8'h30, 2'd0);
        join_ch(8'hC0, 2'd2);
        check("R7 two lines low", 32'(line_o), 32'hA);
        finish_ctl(8'hC0);
        check("R7 only ch2 rises", 32'(line_o), 32'hE);
        step();
        check("R7 only ch2 group released", 32'(release_o), 32'hC0);
        step();
        finish_ctl(8'h30);
        step();
        check("R7 ch0 group released later", 32'(release_o), 32'h30);
        step();
    endtask

    task automatic t_hold();
        hold_i = 4'h8;
        #1;
        check("R8 hold forces low", 32'(line_o), 32'h7);
        join_ch(8'h01, 2'd3);
        finish_ctl(8'h01);
        step();
        step();
        check("R8 no release under hold", 32'(release_o), 32'h0);
        hold_i = 4'h0;
        #1;
        check("R3 line high once hold drops", 32'(line_o), 32'hF);
        step();
        check("R8 release after hold drops", 32'(release_o), 32'h01);
        step();
        check("R5 pulse ends", 32'(release_o), 32'h0);
    endtask

    task automatic t_idle();
        step();
        check("R9 idle lines high", 32'(line_o), 32'hF);
        step();
        check("R9 no release for idle", 32'(release_o), 32'h0);
    endtask

    task automatic t_ignore();
        finish_ctl(8'h20);
        check("R10 done on idle has no pull", 32'(line_o), 32'hF);
        step();
        check("R10 done on idle no release", 32'(release_o), 32'h0);
        sel_i[5*CW +: CW] = 2'd2;
        init_i = 8'h20;
        done_i = 8'h20;
        step();
        init_i = '0;
        done_i = '0;
        check("R10 init wins over done", 32'(line_o), 32'hB);
        join_ch(8'h20, 2'd0);
        check("R10 init ignored while pulling", 32'(line_o), 32'hB);
        finish_ctl(8'h20);
        step();
        check("R10 release on original ch", 32'(release_o), 32'h20);
        step();
        hold_i = 4'h2;
        join_ch(8'h40, 2'd1);
        finish_ctl(8'h40);
        join_ch(8'h40, 2'd3);
        check("R10 init ignored while waiting", 32'(line_o), 32'hD);
        hold_i = 4'h0;
        step();
        check("R10 waiting ctl released", 32'(release_o), 32'h40);
        step();
        check("R10 no rejoin after release", 32'(line_o), 32'hF);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=hang expected=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_indep();
        t_hold();
        t_idle();
        t_ignore();
        summary();
    end

endmodule